// File: doc/BRIEF.md
# Two-Input Four-Phase Handshake Multiplexer

This block joins two passive push channels, `a` and `b`, onto one active push channel, `c`. Every channel has a request, an acknowledge and a bundled data bus. The channels use return-to-zero (four-phase) signalling. When exactly one input raises its request, the block captures that input's data and places it on `c_data`. One cycle later it raises `c_req`. It then passes `c_ack` back to the chosen input through both the rising and the falling phase. After the output handshake has returned to zero, it clears `c_data` to all zeros.

The block does no arbitration. The surrounding logic must never assert both input requests together. If it does, the block only reports the violation with a one-cycle error pulse and does not start an output transfer. The choice of input and the captured data are held in registers until the input request drops, so the input buses may change once capture has happened.

Top module: `hsk_mux2`

## Requirements
- R1: After reset, `c_req`, `a_ack`, `b_ack` and `overlap_err` are 0 and `c_data` is all zeros.
- R2: When only `a_req` is sampled high in idle, `c_data` equals `a_data` after that edge while `c_req` is still 0, and `c_req` rises on the following edge, so the data leads the request.
- R3: When only `b_req` is sampled high in idle, the same sequence runs with `b_data`.
- R4: `c_data` does not change while `c_req` is high.
- R5: The acknowledge of the selected input equals `c_ack` in both phases, and the acknowledge of the other input stays 0; `a_ack` and `b_ack` are never both high.
- R6: `c_req` falls on the first edge at which the selected request is low and `c_ack` is high; `c_data` is all zeros from the edge after `c_ack` is seen low.
- R7: When both input requests are high, `overlap_err` is 1 for exactly one cycle, starting one edge after they are first seen together, and no output request is raised.
- R8: Changes to the selected input's data after capture have no effect on `c_data`.
- R9: A transfer on one input can follow directly after a completed transfer on the other input, and each delivers its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | Request on input channel a |
| a_ack | output | 1 | Acknowledge on input channel a |
| a_data | input | W | Data of input channel a |
| b_req | input | 1 | Request on input channel b |
| b_ack | output | 1 | Acknowledge on input channel b |
| b_data | input | W | Data of input channel b |
| c_req | output | 1 | Request on output channel c |
| c_ack | input | 1 | Acknowledge on output channel c |
| c_data | output | W | Data of output channel c, zero when no transfer is active |
| overlap_err | output | 1 | One-cycle pulse when both input requests are high |

## Verification
Single transfers on `a` and on `b` show that the selection follows whichever request is raised, and that the data arrives one cycle before the request. Transfers with different acknowledge delays on `c` show whether the input acknowledge really tracks `c_ack` rather than a fixed timing. Corrupting the input bus right after capture separates a registered hold from a live path. A window with both requests high, and back-to-back transfers on alternating inputs, show that an overlap is only flagged and that the selection is reset properly between transfers.

// File: rtl/hsk_mux2.sv
module hsk_mux2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_req,
  output logic         a_ack,
  input  logic [W-1:0] a_data,
  input  logic         b_req,
  output logic         b_ack,
  input  logic [W-1:0] b_data,
  output logic         c_req,
  input  logic         c_ack,
  output logic [W-1:0] c_data,
  output logic         overlap_err
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_REQ, S_REL} st_t;

  st_t         st;
  logic        sel_b;
  logic [W-1:0] hold;
  logic        both_q;
  logic        err_q;

  wire both    = a_req & b_req;
  wire sel_req = sel_b ? b_req : a_req;
  wire active  = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sel_b  <= 1'b0;
      hold   <= '0;
      both_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      both_q <= both;
      err_q  <= both & ~both_q;
      case (st)
        S_IDLE:
          if (a_req ^ b_req) begin
            sel_b <= b_req;
            hold  <= b_req ? b_data : a_data;
            st    <= S_LOAD;
          end
        S_LOAD: st <= S_REQ;
        S_REQ:
          if (c_ack && !sel_req) st <= S_REL;
        S_REL:
          if (!c_ack) begin
            hold <= '0;
            st   <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign c_req       = (st == S_REQ);
  assign c_data      = hold;
  assign a_ack       = active & ~sel_b & c_ack;
  assign b_ack       = active &  sel_b & c_ack;
  assign overlap_err = err_q;

endmodule

module hsk_mux2_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         a_req,
  input logic         b_req,
  input logic         a_ack,
  input logic         b_ack,
  input logic         c_req,
  input logic         c_ack,
  input logic [W-1:0] c_data,
  input logic         overlap_err
);

  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (c_req && $past(c_req)) |-> $stable(c_data));

  a_r2_data_before_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(c_req) |-> $stable(c_data));

  a_r5_acks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_ack && b_ack));

  a_r5_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ack || b_ack) |-> c_ack);

  a_r6_cleared_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(c_ack) && !a_req && !b_req) |=> (c_data == '0));

  a_r7_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_err |=> !overlap_err);

  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overlap_err) |-> $past(a_req && b_req));

endmodule

bind hsk_mux2 hsk_mux2_chk #(.W(W)) u_chk (.*);

// File: tb/hsk_mux2_tb.sv
module hsk_mux2_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_req = 1'b0, b_req = 1'b0, c_ack = 1'b0;
  logic [W-1:0] a_data = '0, b_data = '0;
  logic a_ack, b_ack, c_req, overlap_err;
  logic [W-1:0] c_data;

  int checks = 0;
  int errors = 0;
  int rx_delay = 0;
  int rx_cnt = 0;
  bit done = 0;
  logic [W-1:0] expq[$];

  always #10 clk = ~clk;

  hsk_mux2 #(.W(W)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // output-side receiver and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && c_req && !c_ack) begin
        if (rx_cnt >= rx_delay) begin
          if (expq.size() == 0) chk(0, "R2/R3 unexpected transfer", int'(c_data), 0);
          else begin
            logic [W-1:0] e;
            e = expq.pop_front();
            chk(c_data == e, "R2/R3 delivered data", int'(c_data), int'(e));
          end
          c_ack <= 1'b1;
          rx_cnt = 0;
        end else rx_cnt++;
      end else if (!c_req && c_ack) c_ack <= 1'b0;
    end
  end

  task automatic send(input bit use_b, input logic [W-1:0] d);
    logic xa, oa;
    expq.push_back(d);
    @(negedge clk);
    if (use_b) begin b_data = d; b_req = 1'b1; end
    else begin a_data = d; a_req = 1'b1; end
    @(negedge clk);
    chk(c_data == d && !c_req, "R2/R3 data leads request", int'(c_data), int'(d));
    if (use_b) b_data = ~d; else a_data = ~d;   // R8
    @(negedge clk);
    chk(c_req == 1'b1, "R2/R3 request raised", int'(c_req), 1);
    do begin
      @(negedge clk);
      xa = use_b ? b_ack : a_ack;
      oa = use_b ? a_ack : b_ack;
      if (c_req) chk(c_data == d, "R4 R8 data held", int'(c_data), int'(d));
      chk(xa == c_ack && !oa, "R5 ack follows c_ack rising", int'(xa), int'(c_ack));
    end while (!xa);
    if (use_b) b_req = 1'b0; else a_req = 1'b0;
    @(negedge clk);
    chk(!c_req, "R6 c_req falls after input request", int'(c_req), 0);
    do begin
      xa = use_b ? b_ack : a_ack;
      oa = use_b ? a_ack : b_ack;
      chk(xa == c_ack && !oa, "R5 ack follows c_ack falling", int'(xa), int'(c_ack));
      if (xa) @(negedge clk);
    end while (xa);
    @(negedge clk);
    chk(c_data == '0 && !c_req, "R6 data cleared", int'(c_data), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!c_req && !a_ack && !b_ack && !overlap_err && c_data == '0,
        "R1 reset state", int'(c_data), 0);
    rst_n = 1'b1;
    send(0, 8'h5A);
    send(1, 8'hC3);
    rx_delay = 3;
    send(0, 8'h00);
    send(1, 8'hFF);
    rx_delay = 1;
    // R9 back to back alternating
    send(1, 8'h11);
    send(0, 8'h22);
    send(1, 8'h33);
    // R7 overlap
    @(negedge clk);
    a_data = 8'hAA; b_data = 8'hBB; a_req = 1'b1; b_req = 1'b1;
    @(negedge clk);
    chk(overlap_err == 1'b1, "R7 error pulse", int'(overlap_err), 1);
    chk(!c_req && c_data == '0, "R7 no capture", int'(c_data), 0);
    @(negedge clk);
    chk(overlap_err == 1'b0, "R7 error one cycle", int'(overlap_err), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!c_req && !a_ack && !b_ack, "R7 no output request", int'(c_req), 0);
    end
    a_req = 1'b0; b_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(!c_req && c_data == '0, "R7 still idle", int'(c_data), 0);
    send(0, 8'h7E);
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R9 scoreboard drained", expq.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule